// File: doc/BRIEF.md
# Two-Wire Serial Memory Target with Write Protection

This block is the target side of a two-wire serial bus in front of a byte-wide memory array. It watches the clock and data lines, detects start and stop conditions, and accepts a device select byte. That byte carries a fixed type code, the settings of three board strap pins and a read/write flag. On a write it takes a two-byte word address and then data bytes. On a read it streams bytes from an internal address pointer. The data line is open-drain: the block only ever pulls it low, through an output enable. Both bus lines are sampled by the system clock through a two-stage synchronizer.

Written bytes are first collected in a page buffer. They are copied into the array only when the controller sends a stop. A busy window follows each copy, and during it the block will not answer its own device select. A write-protect input is captured at every start condition. While that captured value is high, the block still acknowledges the select byte and both address bytes, but it refuses every data byte and leaves the array unchanged. The array depth is a parameter (`ARRAY_AW` address bits). The 14-bit word address is fully decoded, and addresses alias modulo the array size when `ARRAY_AW` is below 14.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A select byte is acknowledged only when its upper four bits are 1010 and bits 3..1 equal `strap_i`; bit 0 is the direction (0 = write, 1 = read). A non-matching byte is not acknowledged, and the block stays silent until the next start or stop.
- R2: After a write select, two address bytes follow and both are acknowledged. Bits 5..0 of the first byte form pointer bits 13..8, its bits 7..6 are ignored, and the second byte forms bits 7..0.
- R3: Each data byte is acknowledged and placed in a page buffer of 2**PAGE_AW bytes (64 by default). Only the low PAGE_AW bits of the pointer advance, so writes wrap inside the page. The buffer is committed to the array only at a stop that follows at least one accepted data byte. A repeated start throws away uncommitted data.
- R4: `wp_i` is sampled at each start condition and held until the next one. While the held value is 1, select and address bytes are still acknowledged, but data bytes are not, the array is not modified and no busy window starts. A change of `wp_i` after the start has no effect on that transaction.
- R5: A commit raises `busy_o` for exactly BUSY_CYCLES clock cycles. While `busy_o` is high, no select byte is acknowledged.
- R6: A read returns the byte at the pointer and then increments the pointer across the full 14-bit range (0x3FFF is followed by 0x0000). The array stores 2**ARRAY_AW bytes, indexed by the low ARRAY_AW pointer bits. Bytes keep flowing while the controller acknowledges; a non-acknowledge releases the bus and ends the read.
- R7: The block changes `sda_oe_o` only while SCL is low. An acknowledge holds SDA low across the whole ninth SCL high period.
- R8: After reset, `sda_oe_o` and `busy_o` are 0.
- R9: A write select with an address but no data, followed by a repeated start and a read select, reads from the new address. No commit and no busy window result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Board address straps compared with select bits 3..1 |
| wp_i | input | 1 | Write protect, 1 blocks all array writes |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| busy_o | output | 1 | Array commit in progress |

## Verification
The bench writes a page starting two bytes before its end. A design that advanced the full pointer would place the last two bytes in the next page instead of at the page start. It toggles the protect pin between the address and data phases. A design that read the pin live would refuse data that should be stored. It sends a write select just after a stop. A target that ignored busy would acknowledge it. It reads across 0x3FFF with the don't-care address bits set. A decoder that kept those bits, or a pointer that wrapped early, returns the wrong byte. It also ends a write with a repeated start. A design that kept the buffered data would commit it at the next stop.

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int ARRAY_AW    = 11,
  parameter int PAGE_AW     = 6,
  parameter int BUSY_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int WORD_AW = 14;
  localparam int PAGE_N  = 1 << PAGE_AW;
  localparam int ARR_N   = 1 << ARRAY_AW;
  localparam int CNT_W   = $clog2(BUSY_CYCLES + 1);
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t                state;
  logic [3:0]         bitc;
  logic [7:0]         shreg, outb;
  logic [WORD_AW-1:0] ptr;
  logic [5:0]         hi_q;
  logic               rw_q, mack, wp_lat, oe, busy, any_data;
  logic [PAGE_N-1:0]  pvalid;
  logic [CNT_W-1:0]   bcnt;
  logic [PAGE_AW:0]   cidx;
  logic               in_wr, dev_hit, wr_take, commit_en;
  logic [7:0]         rd_byte;

  logic [7:0] mem  [ARR_N];
  logic [7:0] pbuf [PAGE_N];

  assign scl_rise  =  scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] &  scl_q[2];
  assign start_det =  scl_q[1] & scl_q[2] &  sda_q[2] & ~sda_q[1];
  assign stop_det  =  scl_q[1] & scl_q[2] & ~sda_q[2] &  sda_q[1];

  assign in_wr     = (state == S_WR);
  assign dev_hit   = (shreg[7:4] == TYPE_CODE) && (shreg[3:1] == strap_i) && !busy;
  assign wr_take   = scl_fall && !start_det && !stop_det && in_wr && (bitc == 4'd8) && !wp_lat;
  assign commit_en = busy && !cidx[PAGE_AW] && pvalid[cidx[PAGE_AW-1:0]];
  assign rd_byte   = mem[ptr[ARRAY_AW-1:0]];

  assign sda_oe_o  = oe;
  assign busy_o    = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) pbuf[ptr[PAGE_AW-1:0]] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (commit_en) mem[{ptr[ARRAY_AW-1:PAGE_AW], cidx[PAGE_AW-1:0]}] <= pbuf[cidx[PAGE_AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitc     <= '0;
      shreg    <= '0;
      outb     <= '0;
      ptr      <= '0;
      hi_q     <= '0;
      rw_q     <= 1'b0;
      mack     <= 1'b0;
      wp_lat   <= 1'b0;
      oe       <= 1'b0;
      busy     <= 1'b0;
      any_data <= 1'b0;
      pvalid   <= '0;
      bcnt     <= '0;
      cidx     <= '0;
    end else begin
      if (busy) begin
        if (!cidx[PAGE_AW]) cidx <= cidx + 1'b1;
        if (bcnt == CNT_W'(1)) busy <= 1'b0;
        bcnt <= bcnt - 1'b1;
      end
      if (start_det) begin
        state  <= S_DEV;
        bitc   <= '0;
        oe     <= 1'b0;
        wp_lat <= wp_i;
        if (!busy) begin
          pvalid   <= '0;
          any_data <= 1'b0;
        end
      end else if (stop_det) begin
        state <= S_IDLE;
        bitc  <= '0;
        oe    <= 1'b0;
        if (any_data && !busy) begin
          busy     <= 1'b1;
          bcnt     <= CNT_W'(BUSY_CYCLES);
          cidx     <= '0;
          any_data <= 1'b0;
        end
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (bitc < 4'd8) shreg <= {shreg[6:0], sda_q[1]};
          if (bitc == 4'd8) mack <= ~sda_q[1];
          bitc <= bitc + 1'b1;
        end else if (scl_fall) begin
          if (bitc == 4'd8) begin
            case (state)
              S_DEV: begin
                if (dev_hit) begin
                  oe   <= 1'b1;
                  rw_q <= shreg[0];
                end else begin
                  state <= S_IDLE;
                end
              end
              S_AHI: begin
                oe   <= 1'b1;
                hi_q <= shreg[5:0];
              end
              S_ALO: begin
                oe  <= 1'b1;
                ptr <= {hi_q, shreg};
              end
              S_WR: begin
                if (!wp_lat) begin
                  oe                      <= 1'b1;
                  pvalid[ptr[PAGE_AW-1:0]] <= 1'b1;
                  any_data                <= 1'b1;
                  ptr[PAGE_AW-1:0]        <= ptr[PAGE_AW-1:0] + 1'b1;
                end
              end
              S_RD:    oe <= 1'b0;
              default: oe <= 1'b0;
            endcase
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            case (state)
              S_DEV: begin
                if (rw_q) begin
                  state <= S_RD;
                  outb  <= rd_byte;
                  ptr   <= ptr + 1'b1;
                  oe    <= ~rd_byte[7];
                end else begin
                  state <= S_AHI;
                  oe    <= 1'b0;
                end
              end
              S_AHI: begin
                state <= S_ALO;
                oe    <= 1'b0;
              end
              S_ALO: begin
                state <= S_WR;
                oe    <= 1'b0;
              end
              S_RD: begin
                if (mack) begin
                  outb <= rd_byte;
                  ptr  <= ptr + 1'b1;
                  oe   <= ~rd_byte[7];
                end else begin
                  state <= S_IDLE;
                  oe    <= 1'b0;
                end
              end
              default: oe <= 1'b0;
            endcase
          end else if (state == S_RD && bitc != 4'd0) begin
            oe <= ~outb[3'd7 - bitc[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk #(
  parameter int BUSY_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_o,
  input logic wp_lat,
  input logic in_wr
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (busy_o) run <= run + 1;
    else run <= 0;
  end

  assert_oe_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  assert_busy_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run < BUSY_CYCLES));

  assert_protect_no_data_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && wp_lat) |-> !sda_oe_o);

  assert_protect_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !wp_lat);
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .wp_lat(wp_lat), .in_wr(in_wr)
);

// File: tb/sim_eeprom_i2c_target.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_target;
  localparam int AAW  = 11;
  localparam int BUSY = 600;
  localparam int Q    = 8;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic sda_oe, busy;
  wire  sda = ~(m_low | sda_oe);

  always #2 clk = ~clk;

  eeprom_i2c_target #(.ARRAY_AW(AAW), .PAGE_AW(6), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .strap_i(3'b101),
    .wp_i(wp), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  int total = 0, fails = 0;
  logic [7:0] mm [int];
  int mptr = 0;
  int busy_run = 0, r7_bad = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != oe_prev && scl) r7_bad++;
      oe_prev = sda_oe;
      if (busy) busy_run++;
      else if (busy_run != 0) begin
        chk(busy_run == BUSY, "R5 busy length", busy_run, BUSY);
        busy_run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_up();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
    m_low = 0; tick(Q); scl = 1; tick(Q); ack = (sda == 1'b0);
    tick(Q); scl = 0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1; tick(Q); b[i] = sda; tick(Q); scl = 0;
    end
    tick(Q); m_low = give_ack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); m_low = 0;
  endtask

  function automatic int amask(input int a);
    return a & ((1 << AAW) - 1);
  endfunction

  task automatic send_addr(input int addr, input logic [1:0] dc, input string tag);
    bit a;
    send_byte({dc, 6'(addr >> 8)}, a); chk(a, {tag, " R2 upper ack"}, a, 1);
    send_byte(8'(addr), a);            chk(a, {tag, " R2 lower ack"}, a, 1);
  endtask

  task automatic write_tx(input int addr, input logic [1:0] dc, input logic [7:0] d[$],
                          input bit flip_wp, input string tag);
    bit a, prot;
    int off, base;
    prot = wp;
    i2c_start();
    send_byte(DEV_W, a); chk(a, {tag, " R1 select ack"}, a, 1);
    send_addr(addr, dc, tag);
    if (flip_wp) wp = ~wp;
    base = addr & 16'h3FC0;
    off  = addr & 63;
    foreach (d[i]) begin
      send_byte(d[i], a);
      chk(a == !prot, {tag, " R3/R4 data ack"}, a, !prot);
      if (!prot) begin
        mm[amask(base + off)] = d[i];
        off = (off + 1) & 63;
      end
    end
    mptr = base + off;
    i2c_stop();
    tick(4);
    chk(busy == !prot, {tag, " R4/R5 busy after stop"}, busy, !prot);
  endtask

  task automatic wait_ready();
    while (busy) tick(1);
    tick(10);
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      chk(b == mm[amask(mptr)], {tag, " R6 read data"}, b, mm[amask(mptr)]);
      mptr = (mptr + 1) & 16'h3FFF;
    end
    i2c_stop();
  endtask

  task automatic read_at(input int addr, input logic [1:0] dc, input int n, input string tag);
    bit a;
    i2c_start();
    send_byte(DEV_W, a); chk(a, {tag, " R1 select ack"}, a, 1);
    send_addr(addr, dc, tag);
    mptr = addr & 16'h3FFF;
    i2c_start();
    send_byte(DEV_R, a); chk(a, {tag, " R9 read select ack"}, a, 1);
    read_bytes(n, tag);
    tick(4);
    chk(busy == 0, {tag, " R9 no busy"}, busy, 0);
  endtask

  task automatic bad_select(input logic [7:0] sel, input string tag);
    bit a;
    i2c_start();
    send_byte(sel, a);
    chk(a == 0, tag, a, 0);
    i2c_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] dq[$];
    tick(5);
    chk(sda_oe == 0 && busy == 0, "R8 reset outputs", {sda_oe, busy}, 0);
    rst_n = 1;
    tick(10);
    chk(sda_oe == 0 && busy == 0, "R8 after reset", {sda_oe, busy}, 0);

    dq = '{8'h11, 8'h22, 8'h33};
    write_tx(16'h0105, 2'b00, dq, 0, "basic");
    wait_ready();
    read_at(16'h0105, 2'b00, 3, "basic");

    dq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    write_tx(16'h013E, 2'b00, dq, 0, "R3 page wrap");
    wait_ready();
    read_at(16'h0100, 2'b00, 2, "R3 wrap low");
    read_at(16'h013E, 2'b00, 2, "R3 wrap high");

    bad_select(8'hA0, "R1 wrong strap nack");
    bad_select(8'hBA, "R1 wrong type nack");
    tick(4);
    chk(busy == 0, "R1 ignored select no busy", busy, 0);

    dq = '{8'h77};
    write_tx(16'h0200, 2'b00, dq, 0, "busy");
    bad_select(DEV_W, "R5 select nack while busy");
    wait_ready();

    wp = 1;
    dq = '{8'hEE, 8'hEF};
    write_tx(16'h0105, 2'b00, dq, 0, "R4 protected");
    wp = 0;
    read_at(16'h0105, 2'b00, 2, "R4 unchanged");

    dq = '{8'h5C};
    write_tx(16'h0300, 2'b00, dq, 1, "R4 latched");
    wp = 0;
    wait_ready();
    read_at(16'h0300, 2'b00, 1, "R4 latched");

    i2c_start();
    send_byte(DEV_W, a); chk(a, "R3 restart select", a, 1);
    send_addr(16'h0105, 2'b00, "R3 restart");
    send_byte(8'h99, a); chk(a, "R3 restart data ack", a, 1);
    i2c_start();
    i2c_stop();
    tick(4);
    chk(busy == 0, "R3 restart discards, no busy", busy, 0);
    read_at(16'h0105, 2'b00, 1, "R3 restart discard");

    dq = '{8'h5A};
    write_tx(16'h3FFF, 2'b00, dq, 0, "R6 top");
    wait_ready();
    dq = '{8'hA5, 8'hB6};
    write_tx(16'h0000, 2'b00, dq, 0, "R6 bottom");
    wait_ready();
    read_at(16'h3FFF, 2'b11, 2, "R6 R2 wrap with dc bits");

    i2c_start();
    send_byte(DEV_R, a); chk(a, "R6 current read select", a, 1);
    read_bytes(1, "R6 current address");

    tick(20);
    chk(r7_bad == 0, "R7 oe changed while scl high", r7_bad, 0);
    done = 1;
    finish_up();
  end
endmodule